// File: doc/BRIEF.md
# Modulus Down-Counter Latch Timebase

This block is a reloadable down-counter that serves as the periodic timebase of a capture-timer subsystem. It counts down once on each cycle where a prescaled enable input is high and the block is running. When it runs out it gives two signals. The first is a single-cycle latch strobe, which tells the buffered capture channels and the pulse-accumulator holding logic to copy their values. The second is a sticky interrupt flag. The flag can also be used on its own, with no capture logic attached, as a periodic interrupt source.

Software programs the block through a small write port. Select 0 writes the modulus. A nonzero value loads both the reload register and the live count. A zero value clears the count and fires the latch strobe at once. Select 1 writes the control word, which holds:

- the run enable;
- free-run or one-shot selection;
- the interrupt enable;
- a self-clearing force-latch request;
- a write-one-to-clear bit for the flag.

Top module: `mdc_timebase`

## Requirements
- R1: After reset the count, the reload value, all control fields (`ctl_o` = 0), `flag_o`, `irq_o` and `latch_o` are zero.
- R2: A write with `wr_sel`=0 and nonzero `wr_data` sets both the reload value and `count_o` to `wr_data` on the next edge, and it does not strobe `latch_o`.
- R3: `count_o` decrements by one only on edges where control bit 0 (run) is 1 and `tick_en` is 1. Otherwise it holds.
- R4: A qualified tick while `count_o` is 1 is an expiry. It raises `latch_o` for exactly one cycle and sets `flag_o`.
- R5: With control bit 1 (periodic) at 1, an expiry reloads `count_o` from the reload value. The strobes therefore repeat every reload-value ticks.
- R6: With control bit 1 at 0, an expiry leaves `count_o` at 0. Further ticks cause no change and no strobe.
- R7: A write with `wr_sel`=0 and `wr_data`=0 clears `count_o` and raises `latch_o` for one cycle on the next edge. It leaves `flag_o` and the reload value unchanged.
- R8: A control write (`wr_sel`=1) with bit 3 at 1 raises `latch_o` for one cycle. `ctl_o[3]` always reads 0.
- R9: A control write with bit 4 at 1 clears `flag_o`. If an expiry falls on the same edge, the flag stays set.
- R10: `irq_o` is high exactly when `flag_o` is 1 and control bit 2 (interrupt enable) is 1.
- R11: A modulus write takes priority over a tick on the same edge. The count takes the written value and no expiry occurs.
- R12: A control write sets run, periodic and interrupt enable from `wr_data` bits 0, 1 and 2. These are shown on `ctl_o[0]`, `ctl_o[1]` and `ctl_o[2]`, and take effect from the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Prescaled count enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = modulus/count, 1 = control |
| wr_data | input | 16 | Write data |
| count_o | output | 16 | Current count |
| ctl_o | output | 4 | Control readback {force(0), irq_en, periodic, run} |
| latch_o | output | 1 | One-cycle latch strobe to capture holding logic |
| flag_o | output | 1 | Sticky expiry flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume the following about this block's inputs:

- `rst` is synchronous.
- Each write is a single-cycle pulse whose select and data are stable around the edge.
- Expiry depends only on the registered run bit, not on a control write in the same cycle.

The random stimulus keeps to these rules by driving every input away from the clock edge. It draws modulus values between 0 and 5, so both expiries and zero-writes occur often. It keeps the run bit set in most control writes, so the counting paths are used heavily.

// File: rtl/mdc_pkg.sv
package mdc_pkg;

    localparam int unsigned CNT_W   = 16;
    localparam int unsigned BIT_RUN = 0;
    localparam int unsigned BIT_PER = 1;
    localparam int unsigned BIT_IE  = 2;
    localparam int unsigned BIT_FRC = 3;
    localparam int unsigned BIT_CLR = 4;

    typedef enum logic {
        SEL_MOD = 1'b0,
        SEL_CTL = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic irq_en;
        logic periodic;
        logic run;
    } cfg_t;

    typedef struct packed {
        logic load;
        logic zero_load;
        logic force_latch;
        logic flag_clr;
    } wr_evt_t;

    function automatic logic any_mod_write(input wr_evt_t e);
        return e.load | e.zero_load;
    endfunction

endpackage

// File: rtl/mdc_ctl_regs.sv
module mdc_ctl_regs
    import mdc_pkg::*;
#(
    parameter int unsigned CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [CW-1:0] wr_data,
    output cfg_t          cfg,
    output wr_evt_t       evt
);

    logic is_mod;
    logic is_ctl;

    always_comb begin
        is_mod          = wr_en && (reg_sel_e'(wr_sel) == SEL_MOD);
        is_ctl          = wr_en && (reg_sel_e'(wr_sel) == SEL_CTL);
        evt.load        = is_mod && (wr_data != '0);
        evt.zero_load   = is_mod && (wr_data == '0);
        evt.force_latch = is_ctl && wr_data[BIT_FRC];
        evt.flag_clr    = is_ctl && wr_data[BIT_CLR];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (is_ctl) begin
            cfg.run      <= wr_data[BIT_RUN];
            cfg.periodic <= wr_data[BIT_PER];
            cfg.irq_en   <= wr_data[BIT_IE];
        end
    end

    // R12: control fields follow a control write
    a_r12_cfg_update: assert property (@(posedge clk) disable iff (rst)
        is_ctl |=> (cfg.run == $past(wr_data[BIT_RUN])) &&
                   (cfg.periodic == $past(wr_data[BIT_PER])));

endmodule

// File: rtl/mdc_counter.sv
module mdc_counter
    import mdc_pkg::*;
#(
    parameter int unsigned CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_en,
    input  logic [CW-1:0] wr_data,
    input  cfg_t          cfg,
    input  wr_evt_t       evt,
    output logic [CW-1:0] count,
    output logic          expire
);

    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] reload_q;
    logic          step;
    logic          mod_wr;

    always_comb begin
        mod_wr = any_mod_write(evt);
        step   = cfg.run && tick_en && !mod_wr;
        expire = step && (count == ONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count    <= '0;
            reload_q <= '0;
        end else if (evt.load) begin
            count    <= wr_data;
            reload_q <= wr_data;
        end else if (evt.zero_load) begin
            count <= '0;
        end else if (expire) begin
            count <= cfg.periodic ? reload_q : '0;
        end else if (step && (count != '0)) begin
            count <= count - ONE;
        end
    end

    // R3: no qualified tick and no write -> count holds
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!(cfg.run && tick_en) && !mod_wr) |=> $stable(count));

    // R3: qualified tick above one decrements
    a_r3_dec: assert property (@(posedge clk) disable iff (rst)
        (step && count > ONE) |=> count == $past(count) - ONE);

    // R5: periodic expiry reloads
    a_r5_reload: assert property (@(posedge clk) disable iff (rst)
        (expire && cfg.periodic) |=> count == $past(reload_q));

    // R6: one-shot expiry stops at zero
    a_r6_stop: assert property (@(posedge clk) disable iff (rst)
        (expire && !cfg.periodic) |=> count == '0);

    // R11: a modulus write wins over a tick
    a_r11_load_wins: assert property (@(posedge clk) disable iff (rst)
        evt.load |=> count == $past(wr_data));

endmodule

// File: rtl/mdc_event.sv
module mdc_event
    import mdc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    expire,
    input  wr_evt_t evt,
    output logic    latch_o,
    output logic    flag_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_o <= 1'b0;
            flag_o  <= 1'b0;
        end else begin
            latch_o <= expire | evt.zero_load | evt.force_latch;
            if (expire) begin
                flag_o <= 1'b1;
            end else if (evt.flag_clr) begin
                flag_o <= 1'b0;
            end
        end
    end

    // R4: expiry strobes and sets the flag
    a_r4_expire: assert property (@(posedge clk) disable iff (rst)
        expire |=> latch_o && flag_o);

    // R7: zero write strobes, flag untouched
    a_r7_zero: assert property (@(posedge clk) disable iff (rst)
        (evt.zero_load && !expire) |=> latch_o && (flag_o == $past(flag_o)));

    // R8: force request strobes
    a_r8_force: assert property (@(posedge clk) disable iff (rst)
        evt.force_latch |=> latch_o);

    // R9: clear without expiry drops the flag
    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        (evt.flag_clr && !expire) |=> !flag_o);

endmodule

// File: rtl/mdc_timebase.sv
module mdc_timebase
    import mdc_pkg::*;
#(
    parameter int unsigned CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_en,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] count_o,
    output logic [3:0]    ctl_o,
    output logic          latch_o,
    output logic          flag_o,
    output logic          irq_o
);

    cfg_t    cfg;
    wr_evt_t evt;
    logic    expire;

    mdc_ctl_regs #(.CW(CW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .cfg     (cfg),
        .evt     (evt)
    );

    mdc_counter #(.CW(CW)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .wr_data (wr_data),
        .cfg     (cfg),
        .evt     (evt),
        .count   (count_o),
        .expire  (expire)
    );

    mdc_event u_evt (
        .clk     (clk),
        .rst     (rst),
        .expire  (expire),
        .evt     (evt),
        .latch_o (latch_o),
        .flag_o  (flag_o)
    );

    always_comb begin
        ctl_o = {1'b0, cfg.irq_en, cfg.periodic, cfg.run};
        irq_o = flag_o & cfg.irq_en;
    end

    // R10: an interrupt needs the flag
    a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> flag_o);

endmodule

// File: tb/mdc_timebase_test.sv
`timescale 1ns/1ps
module mdc_timebase_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] count_o;
    logic [3:0]  ctl_o;
    logic        latch_o, flag_o, irq_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // bench model state
    logic [15:0] m_count = '0, m_reload = '0;
    logic        m_run = 0, m_per = 0, m_ie = 0, m_flag = 0, m_latch = 0;

    always #2 clk = ~clk;

    mdc_timebase uut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .count_o(count_o),
        .ctl_o(ctl_o), .latch_o(latch_o), .flag_o(flag_o), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] next_count(input logic t, input logic w, input logic s,
                                               input logic [15:0] d, input logic ex);
        if (w && !s) return d;
        if (ex) return m_per ? m_reload : 16'd0;
        if (m_run && t && m_count != 0) return m_count - 16'd1;
        return m_count;
    endfunction

    task automatic model_step(input logic t, input logic w, input logic s, input logic [15:0] d);
        logic ex;
        ex = m_run && t && (m_count == 16'd1) && !(w && !s);
        m_latch = ex || (w && !s && d == 0) || (w && s && d[3]);
        m_count = next_count(t, w, s, d, ex);
        if (w && !s && d != 0) m_reload = d;
        if (ex) m_flag = 1;
        else if (w && s && d[4]) m_flag = 0;
        if (w && s) begin
            m_run = d[0]; m_per = d[1]; m_ie = d[2];
        end
    endtask

    task automatic compare(input string tag);
        check({tag, " count"}, count_o, m_count);
        check({tag, " latch"}, latch_o, m_latch);
        check({tag, " flag"}, flag_o, m_flag);
        check({tag, " irq"}, irq_o, m_flag & m_ie);
        check({tag, " ctl"}, ctl_o, {1'b0, m_ie, m_per, m_run});
    endtask

    task automatic cyc(input string tag, input logic t, input logic w, input logic s,
                       input logic [15:0] d);
        tick_en = t; wr_en = w; wr_sel = s; wr_data = d;
        @(posedge clk);
        model_step(t, w, s, d);
        #1;
        tick_en = 0; wr_en = 0;
        compare(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 count", count_o, 0);
        check("R1 ctl", ctl_o, 0);
        check("R1 flag", flag_o, 0);
        check("R1 latch", latch_o, 0);
        check("R1 irq", irq_o, 0);

        cyc("R2 load", 0, 1, 0, 16'd3);
        check("R2 count", count_o, 3);
        check("R2 no strobe", latch_o, 0);
        cyc("R12 ctl", 0, 1, 1, 16'h0007);
        check("R12 ctl_o", ctl_o, 4'h7);
        cyc("R3 idle", 0, 0, 0, 0);
        check("R3 hold", count_o, 3);
        cyc("R3 tick", 1, 0, 0, 0);
        check("R3 dec", count_o, 2);
        cyc("R3 tick", 1, 0, 0, 0);
        cyc("R4 expiry", 1, 0, 0, 0);
        check("R4 latch", latch_o, 1);
        check("R4 flag", flag_o, 1);
        check("R5 reload", count_o, 3);
        check("R10 irq", irq_o, 1);
        cyc("R4 one cycle", 0, 0, 0, 0);
        check("R4 latch low", latch_o, 0);
        cyc("R10 ie off", 0, 1, 1, 16'h0003);
        check("R10 irq masked", irq_o, 0);
        cyc("R9 clear", 0, 1, 1, 16'h0017);
        check("R9 flag", flag_o, 0);
        cyc("R7 zero", 0, 1, 0, 16'h0000);
        check("R7 latch", latch_o, 1);
        check("R7 count", count_o, 0);
        cyc("R8 force", 0, 1, 1, 16'h000F);
        check("R8 latch", latch_o, 1);
        check("R8 readback", ctl_o[3], 0);
        cyc("R11 load wins", 1, 1, 0, 16'd5);
        check("R11 count", count_o, 5);
        // one-shot
        cyc("R6 cfg", 0, 1, 1, 16'h0001);
        cyc("R6 load", 0, 1, 0, 16'd2);
        cyc("R6 tick", 1, 0, 0, 0);
        cyc("R6 expiry", 1, 0, 0, 0);
        check("R6 strobe", latch_o, 1);
        check("R6 count", count_o, 0);
        cyc("R6 after", 1, 0, 0, 0);
        check("R6 stopped", count_o, 0);
        check("R6 no strobe", latch_o, 0);
        // R9 set wins over clear
        cyc("R9 per", 0, 1, 1, 16'h0003);
        cyc("R9 load", 0, 1, 0, 16'd1);
        cyc("R9 clr", 0, 1, 1, 16'h0013);
        tick_en = 1; wr_en = 1; wr_sel = 1; wr_data = 16'h0013;
        @(posedge clk);
        model_step(1, 1, 1, 16'h0013);
        #1;
        tick_en = 0; wr_en = 0;
        check("R9 set wins", flag_o, 1);
        compare("R9 model");

        for (int i = 0; i < 4000; i++) begin
            logic t, w, s;
            logic [15:0] d;
            t = ($urandom % 3) != 0;
            w = ($urandom % 6) == 0;
            s = $urandom % 2;
            if (s) d = 16'(($urandom % 32) | (($urandom % 4) != 0 ? 1 : 0));
            else   d = 16'($urandom % 6);
            cyc("RND", t, w, s, d);
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule